// File: doc/BRIEF.md
# Host Parallel Port Bridge

This bridge gives an external host controller access to a local memory bus through a strobe-driven port. The port carries address and data over the same 16 lines. The host first performs an address cycle that loads the low 16 bits of a word address. A page register supplies the upper bits. Two chip selects pick the target space: one selects memory and the other selects I/O. Every host input passes through a two-stage synchronizer before the bridge acts on it.

The host side can be 8 or 16 bits wide, and a local word is either 16 or 24 bits. The bridge therefore splits each local word into one, two or three host accesses. On a write, it collects the pieces and posts a single bus write once the last piece arrives. On a read, the first piece triggers a bus read of the whole word, and the bridge serves the remaining pieces from that prefetched copy. After a complete word, the word address steps by one.

A single handshake line paces the host. In acknowledge mode the line is idle low: it rises when an access is complete and falls after the host drops its strobe. In ready mode the line is idle high and goes low only while a bus transfer is pending. Accesses that do not reach memory are answered at once. I/O addresses 0 and 1 are the bridge's own control and page registers.

Top module: `hpb_bridge`

## Requirements
- R1: After reset, host_hs, bus_req and host_ad_oe are all low, and the control register is 0x00: acknowledge mode, address-cycle handshake off, 8-bit host width, 16-bit words.
- R2: Control bits [7:6] select the handshake mode. 00 is acknowledge mode. Any other value is ready mode, in which host_hs sits high while no bus transfer is pending.
- R3: In acknowledge mode, host_hs rises only once the access is complete, stays high while the strobe is held, and returns low after the host removes the strobe.
- R4: In ready mode, host_hs goes low while an access waits for a bus grant or read data, and returns high when that access is complete. An access that needs no bus transfer never pulls it low.
- R5: Control bit 2 selects a 16-bit host width and control bit 3 selects 24-bit words. The number of host accesses per word is 2 for 8-bit/16-bit, 3 for 8-bit/24-bit, 1 for 16-bit/16-bit and 2 for 16-bit/24-bit. Pieces go in order from the least significant end: 8-bit pieces at bits 8k, and 16-bit pieces at bits [15:0] and then [23:16]. A 16-bit word has bits [23:16] written as zero on the bus.
- R6: Every write piece except the last is answered at once, with no bus request. The last piece raises bus_req with bus_we high and the assembled word on bus_wdata. bus_req, bus_addr, bus_we and bus_wdata then hold steady until bus_gnt. The host is answered after the grant.
- R7: A read at piece 0 raises bus_req with bus_we low and is answered once bus_rvalid returns the word. Later pieces of the same word come from the prefetched copy, are answered at once, and issue no bus request. Read data appears on host_ad_out with host_ad_oe high while the read is being answered.
- R8: bus_addr is {page register, low address}. The low address comes from an address cycle, advances by one after each complete word, and wraps from 0xFFFF to 0x0000 without changing the page.
- R9: host_cs_mem accesses drive bus_io low, and host_cs_io accesses drive it high. An I/O access to address 0 reaches the control register and one to address 1 reaches the page register. Both are read and written in the low bits, answered at once, and never make a bus request.
- R10: An address cycle (host_ale) is answered on host_hs when control bit 5 is set. With that bit clear, an address cycle in acknowledge mode leaves host_hs low.
- R11: The piece position returns to 0 when both chip selects are deasserted or when a new address cycle occurs, so a partly built word is discarded.
- R12: Host strobe, chip select and address-latch inputs pass through two synchronizer stages. An access that is answered at once raises host_hs after the third clock edge following the strobe, not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_mem | input | 1 | Host select for the memory space |
| host_cs_io | input | 1 | Host select for the I/O space |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_ale | input | 1 | Host address-cycle strobe |
| host_ad_in | input | 16 | Address or write data from the host |
| host_ad_out | output | 16 | Read data to the host |
| host_ad_oe | output | 1 | Read data valid, drive enable for the shared lines |
| host_hs | output | 1 | Handshake line (acknowledge or ready) |
| bus_req | output | 1 | Local bus request |
| bus_we | output | 1 | Local bus write (1) or read (0) |
| bus_io | output | 1 | Local bus space: 1 = I/O, 0 = memory |
| bus_addr | output | ADDR_W | Local bus word address |
| bus_wdata | output | 24 | Local bus write word |
| bus_gnt | input | 1 | Local bus grant, one cycle |
| bus_rvalid | input | 1 | Local bus read data valid, one cycle |
| bus_rdata | input | 24 | Local bus read word |

## Verification
The assertions check four properties on every cycle:
- a pending bus request keeps its address, direction and data until the grant;
- the piece position never passes the last piece of the current word layout;
- acknowledge-mode host_hs never overlaps a bus request;
- the local register addresses never reach the bus.

Only the bench scenarios can show the following:
- which host piece carries which bits;
- that intermediate pieces are answered without any bus traffic;
- the prefetched read contents;
- address stepping and wrap;
- that a partly built word is discarded after a chip-select drop or a new address cycle;
- the exact edge on which the synchronized handshake answers.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
    localparam int HOST_W = 16;
    localparam int WORD_W = 24;
    localparam int POS_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } hpb_state_e;

    localparam logic [1:0] MODE_ACK = 2'b00;
endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hpb_lanes.sv
module hpb_lanes
    import hpb_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [WORD_W-1:0] wbase,
    input  logic [HOST_W-1:0] host_data,
    input  logic [POS_W-1:0]  pos,
    input  logic              wide,
    input  logic              long_word,
    output logic [WORD_W-1:0] merged,
    output logic [HOST_W-1:0] part,
    output logic [POS_W-1:0]  last_pos
);
    logic [5:0]        shift;
    logic [WORD_W-1:0] lane_mask;
    logic [WORD_W-1:0] ins;
    logic [WORD_W-1:0] mix;
    logic [WORD_W-1:0] picked;

    always_comb begin
        shift     = wide ? {pos, 4'b0000} : {1'b0, pos, 3'b000};
        lane_mask = wide ? 24'h00FFFF : 24'h0000FF;
        ins       = {8'h00, host_data} & lane_mask;
        mix       = (wbase & ~(lane_mask << shift)) | (ins << shift);
        merged    = long_word ? mix : {8'h00, mix[15:0]};
        picked    = (word_in >> shift) & lane_mask;
        part      = picked[HOST_W-1:0];
        if (wide) begin
            last_pos = {1'b0, long_word};
        end else begin
            last_pos = long_word ? 2'd2 : 2'd1;
        end
    end
endmodule

// File: rtl/hpb_bridge.sv
module hpb_bridge
    import hpb_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_mem,
    input  logic              host_cs_io,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              host_ale,
    input  logic [15:0]       host_ad_in,
    output logic [15:0]       host_ad_out,
    output logic              host_ad_oe,
    output logic              host_hs,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_io,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [23:0]       bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_rvalid,
    input  logic [23:0]       bus_rdata
);
    localparam int PAGE_W = ADDR_W - HOST_W;

    typedef struct packed {
        hpb_state_e        st;
        logic [POS_W-1:0]  pos;
        logic [HOST_W-1:0] alo;
        logic [PAGE_W-1:0] page;
        logic [7:0]        ctrl;
        logic [WORD_W-1:0] wbuf;
        logic [WORD_W-1:0] rbuf;
        logic [HOST_W-1:0] rout;
        logic              we;
        logic              io;
        logic              rd;
        logic              hs_en;
        logic              strb_prev;
    } regs_t;

    regs_t q, d;

    // synchronized host controls
    logic [4:0] sync_in, sync_out;
    logic s_cs_mem, s_cs_io, s_rd, s_wr, s_ale;
    assign sync_in = {host_ale, host_wr, host_rd, host_cs_io, host_cs_mem};

    hpb_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    assign {s_ale, s_wr, s_rd, s_cs_io, s_cs_mem} = sync_out;

    logic strb, rise, cs_any, ack_mode, acc, wide, long_word, local_hit;
    assign strb      = s_ale | s_wr | s_rd;
    assign rise      = strb & ~q.strb_prev;
    assign cs_any    = s_cs_mem | s_cs_io;
    assign ack_mode  = (q.ctrl[7:6] == MODE_ACK);
    assign acc       = q.ctrl[5];
    assign long_word = q.ctrl[3];
    assign wide      = q.ctrl[2];
    assign local_hit = s_cs_io && (q.alo[HOST_W-1:1] == '0);

    // lane pack / unpack
    logic [WORD_W-1:0] lane_word, wbase, merged;
    logic [HOST_W-1:0] part;
    logic [POS_W-1:0]  lane_pos, last_pos;

    assign lane_word = (q.st == ST_DATA) ? bus_rdata : q.rbuf;
    assign lane_pos  = (q.st == ST_DATA) ? '0 : q.pos;
    assign wbase     = (q.pos == '0) ? '0 : q.wbuf;

    hpb_lanes u_lanes (
        .word_in   (lane_word),
        .wbase     (wbase),
        .host_data (host_ad_in),
        .pos       (lane_pos),
        .wide      (wide),
        .long_word (long_word),
        .merged    (merged),
        .part      (part),
        .last_pos  (last_pos)
    );

    always_comb begin
        d = q;
        d.strb_prev = strb;
        unique case (q.st)
            ST_IDLE: begin
                if (rise && cs_any) begin
                    d.io    = s_cs_io;
                    d.rd    = s_rd && !s_ale && !s_wr;
                    d.hs_en = 1'b1;
                    d.st    = ST_HOLD;
                    if (s_ale) begin
                        d.alo   = host_ad_in;
                        d.pos   = '0;
                        d.hs_en = acc;
                    end else if (local_hit) begin
                        if (s_wr) begin
                            if (!q.alo[0]) d.ctrl = host_ad_in[7:0];
                            else           d.page = host_ad_in[PAGE_W-1:0];
                            d.pos = '0;
                        end else begin
                            d.rout = q.alo[0] ? HOST_W'(q.page) : {8'h00, q.ctrl};
                        end
                    end else if (s_wr) begin
                        d.wbuf = merged;
                        d.we   = 1'b1;
                        if (q.pos == last_pos) d.st  = ST_BUS;
                        else                   d.pos = q.pos + 1'b1;
                    end else begin
                        d.we = 1'b0;
                        if (q.pos == '0) begin
                            d.st = ST_BUS;
                        end else begin
                            d.rout = part;
                            if (q.pos == last_pos) begin
                                d.pos = '0;
                                d.alo = q.alo + 1'b1;
                            end else begin
                                d.pos = q.pos + 1'b1;
                            end
                        end
                    end
                end
            end
            ST_BUS: begin
                if (bus_gnt) begin
                    if (q.we) begin
                        d.pos = '0;
                        d.alo = q.alo + 1'b1;
                        d.st  = ST_HOLD;
                    end else begin
                        d.st = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (bus_rvalid) begin
                    d.rbuf = bus_rdata;
                    d.rout = part;
                    if (last_pos == '0) begin
                        d.pos = '0;
                        d.alo = q.alo + 1'b1;
                    end else begin
                        d.pos = 2'd1;
                    end
                    d.st = ST_HOLD;
                end
            end
            default: begin
                if (!strb) d.st = ST_IDLE;
            end
        endcase
        if (!cs_any) d.pos = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_req     = (q.st == ST_BUS);
    assign bus_we      = q.we;
    assign bus_io      = q.io;
    assign bus_addr    = {q.page, q.alo};
    assign bus_wdata   = q.wbuf;
    assign host_ad_out = q.rout;
    assign host_ad_oe  = (q.st == ST_HOLD) && q.rd;
    assign host_hs     = ack_mode ? ((q.st == ST_HOLD) && q.hs_en)
                                  : !((q.st == ST_BUS) || (q.st == ST_DATA));

    // R6: request and its payload stay put until the grant
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_wdata) && $stable(bus_io));

    // R5: piece position never passes the last piece of the layout
    a_r5_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.pos <= last_pos);

    // R3: acknowledge-mode handshake never overlaps a pending transfer
    a_r3_ack_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_mode && host_hs |-> !bus_req);

    // R9: the bridge's own register addresses never reach the bus
    a_r9_local_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !(bus_io && (bus_addr[HOST_W-1:1] == '0)));
endmodule

// File: tb/tb_hpb_bridge.sv
`timescale 1ns/100ps
module tb_hpb_bridge;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_cs_mem = 0, host_cs_io = 0, host_rd = 0, host_wr = 0, host_ale = 0;
    logic [15:0] host_ad_in = '0;
    logic [15:0] host_ad_out;
    logic host_ad_oe, host_hs, bus_req, bus_we, bus_io;
    logic [23:0] bus_addr, bus_wdata;
    logic bus_gnt = 0, bus_rvalid = 0;
    logic [23:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    hpb_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .host_cs_mem(host_cs_mem), .host_cs_io(host_cs_io),
        .host_rd(host_rd), .host_wr(host_wr), .host_ale(host_ale),
        .host_ad_in(host_ad_in), .host_ad_out(host_ad_out), .host_ad_oe(host_ad_oe),
        .host_hs(host_hs), .bus_req(bus_req), .bus_we(bus_we), .bus_io(bus_io),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [23:0] mem [2][64];
    int wr_ops = 0, rd_ops = 0;
    logic [23:0] last_addr, last_data;
    logic last_io;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [23:0] init_val(input int io, input int i);
        return 24'hA50000 ^ (24'(i) * 24'h010203) ^ (io != 0 ? 24'h5A5A5A : 24'h0);
    endfunction

    initial begin
        int dly;
        int rcnt;
        bit rpend;
        logic [23:0] rword;
        for (int io = 0; io < 2; io++)
            for (int i = 0; i < 64; i++) mem[io][i] = init_val(io, i);
        dly = 4; rcnt = 0; rpend = 0; rword = '0;
        forever begin
            @(posedge clk); #1;
            bus_gnt = 0;
            bus_rvalid = 0;
            if (rpend) begin
                if (rcnt == 0) begin
                    bus_rvalid = 1;
                    bus_rdata = rword;
                    rpend = 0;
                end else rcnt--;
            end else if (bus_req) begin
                if (dly == 0) begin
                    bus_gnt = 1;
                    seed = seed * 32'd1103515245 + 32'd12345;
                    dly = 4 + int'(seed[9:8]);
                    last_addr = bus_addr;
                    last_io = bus_io;
                    if (bus_we) begin
                        wr_ops++;
                        last_data = bus_wdata;
                        mem[bus_io][bus_addr[5:0]] = bus_wdata;
                    end else begin
                        rd_ops++;
                        rword = mem[bus_io][bus_addr[5:0]];
                        rcnt = 2 + int'(seed[12:11]);
                        rpend = 1;
                    end
                end else dly--;
            end
        end
    end

    // ---------------- host model ----------------
    bit mode_ack = 1, acc_on = 0;
    logic [15:0] r_q;
    int r_wc;
    bit r_low, r_high, r_hs2, r_hs3, r_rel;

    task automatic host_cycle(input int kind, input bit io, input logic [15:0] dat, input bit exp_hs);
        host_cs_mem = !io; host_cs_io = io; host_ad_in = dat;
        if (kind == 0) host_ale = 1; else if (kind == 1) host_wr = 1; else host_rd = 1;
        r_low = 0; r_high = 0; r_wc = 0; r_hs2 = 0; r_hs3 = 0;
        for (int c = 1; c <= 600; c++) begin
            @(posedge clk); #1;
            if (host_hs !== 1'b1) r_low = 1; else r_high = 1;
            if (c == 2) r_hs2 = host_hs;
            if (c == 3) r_hs3 = host_hs;
            r_wc = c;
            if (exp_hs && c >= 6 && host_hs === 1'b1) break;
            if (!exp_hs && c >= 8) break;
        end
        r_q = host_ad_out;
        host_ale = 0; host_wr = 0; host_rd = 0;
        r_rel = 0;
        for (int c = 1; c <= 20; c++) begin
            @(posedge clk); #1;
            if (c >= 5 && (!mode_ack || host_hs === 1'b0)) begin r_rel = 1; break; end
        end
    endtask

    task automatic do_ale(input bit io, input logic [15:0] a, input bit exp_hs);
        host_cycle(0, io, a, exp_hs);
    endtask
    task automatic do_wr(input bit io, input logic [15:0] v);
        host_cycle(1, io, v, 1);
    endtask
    task automatic do_rd(input bit io);
        host_cycle(2, io, 16'h0, 1);
    endtask
    task automatic cs_off(input int n);
        host_cs_mem = 0; host_cs_io = 0;
        repeat (n) begin @(posedge clk); #1; end
    endtask
    task automatic set_cfg(input logic [7:0] v);
        do_ale(1, 16'h0000, acc_on);
        mode_ack = (v[7:6] == 2'b00);
        acc_on = v[5];
        do_wr(1, {8'h00, v});
    endtask

    function automatic logic [15:0] part_of(input logic [23:0] w, input int k, input bit wide);
        if (wide) return (k == 0) ? w[15:0] : {8'h00, w[23:16]};
        return {8'h00, w[8*k +: 8]};
    endfunction
    function automatic int nparts(input bit wide, input bit lng);
        if (wide) return lng ? 2 : 1;
        return lng ? 3 : 2;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [23:0] written [2];
        logic [23:0] word, expw;
        logic [15:0] base;
        int ops0;
        repeat (5) @(posedge clk);
        #1;
        // R1 reset state
        chk(host_hs == 0, "R1 hs after reset", 32'(host_hs), 0);
        chk(bus_req == 0, "R1 req after reset", 32'(bus_req), 0);
        chk(host_ad_oe == 0, "R1 oe after reset", 32'(host_ad_oe), 0);
        rst_n = 1;
        repeat (3) begin @(posedge clk); #1; end

        // R10 off: address cycle without handshake in acknowledge mode
        do_ale(1, 16'h0000, 0);
        chk(!r_high, "R10 address cycle without acc", 32'(r_high), 0);
        // R12 latency on an immediate local write (ACK, acc, wide, 16-bit words)
        mode_ack = 1; acc_on = 1;
        do_wr(1, 16'h0024);
        chk(r_hs2 == 0 && r_hs3 == 1, "R12 handshake edge", {r_hs2, r_hs3}, 32'b01);
        do_ale(1, 16'h0000, 1);
        chk(r_high && r_wc == 6, "R10 address cycle with acc", r_wc, 6);
        ops0 = wr_ops + rd_ops;
        do_rd(1);
        chk(r_q == 16'h0024, "R9 control read back", r_q, 16'h0024);
        chk(wr_ops + rd_ops == ops0, "R9 local access no bus", wr_ops + rd_ops, ops0);
        // page register
        do_ale(1, 16'h0001, 1);
        do_wr(1, 16'h003C);

        // sweep modes and layouts
        for (int m = 0; m < 2; m++) begin
            for (int cf = 0; cf < 4; cf++) begin
                bit wide, lng;
                int n;
                wide = cf[0]; lng = cf[1]; n = nparts(wide, lng);
                set_cfg({(m == 0) ? 2'b00 : 2'b01, 1'b1, 1'b0, lng, wide, 2'b00});
                if (m == 1) chk(host_hs == 1, "R2 ready idles high", 32'(host_hs), 1);
                else        chk(host_hs == 0, "R2 ack idles low", 32'(host_hs), 0);
                base = 16'h0010 + 16'(cf * 4) + 16'(m * 16);
                do_ale(0, base, 1);
                for (int w = 0; w < 2; w++) begin
                    seed = seed * 32'd1103515245 + 32'd12345;
                    word = seed[30:7];
                    expw = lng ? word : {8'h00, word[15:0]};
                    for (int k = 0; k < n; k++) begin
                        ops0 = wr_ops;
                        do_wr(0, part_of(word, k, wide));
                        if (k < n - 1) begin
                            chk(wr_ops == ops0 && r_wc == 6, "R6 early piece answered at once", r_wc, 6);
                            if (m == 1) chk(!r_low, "R4 ready stays high", 32'(r_low), 0);
                        end else begin
                            chk(wr_ops == ops0 + 1 && r_wc > 6, "R6 single posted write", wr_ops - ops0, 1);
                            chk(last_data == expw, "R5 assembled word", last_data, expw);
                            chk(last_addr == {8'h3C, base + 16'(w)} && !last_io, "R8 write address",
                                last_addr, {8'h3C, base + 16'(w)});
                            if (m == 1) chk(r_low, "R4 ready low while waiting", 32'(r_low), 1);
                            else        chk(r_rel, "R3 release after strobe", 32'(r_rel), 1);
                        end
                    end
                    written[w] = expw;
                end
                do_ale(0, base, 1);
                for (int w = 0; w < 2; w++) begin
                    for (int k = 0; k < n; k++) begin
                        ops0 = rd_ops;
                        do_rd(0);
                        chk(r_q == part_of(written[w], k, wide), "R7 read piece", r_q, part_of(written[w], k, wide));
                        chk(rd_ops == ops0 + ((k == 0) ? 1 : 0), "R7 prefetch count", rd_ops - ops0, (k == 0) ? 1 : 0);
                        if (k == 0 && m == 1) chk(r_low, "R4 ready low on read", 32'(r_low), 1);
                        if (k == 0 && m == 0) chk(r_rel, "R3 release after read", 32'(r_rel), 1);
                    end
                end
                base = 16'h0030 + 16'(cf) + 16'(m * 8);
                expw = init_val(0, int'(base[5:0]));
                if (!lng) expw[23:16] = 8'h00;
                do_ale(0, base, 1);
                for (int k = 0; k < n; k++) begin
                    do_rd(0);
                    chk(r_q == part_of(expw, k, wide), "R7 fresh read piece", r_q, part_of(expw, k, wide));
                end
            end
        end

        // R9 I/O space through the bus
        set_cfg(8'h24);
        do_ale(1, 16'h0005, 1);
        do_wr(1, 16'hBEEF);
        chk(last_io == 1 && last_addr == 24'h3C0005 && last_data == 24'h00BEEF,
            "R9 I/O write", last_addr, 24'h3C0005);
        // R8 wrap
        do_ale(0, 16'hFFFF, 1);
        do_wr(0, 16'h1234);
        chk(last_addr == 24'h3CFFFF && last_data == 24'h001234, "R8 top address", last_addr, 24'h3CFFFF);
        do_wr(0, 16'h5678);
        chk(last_addr == 24'h3C0000 && last_data == 24'h005678, "R8 wrap keeps page", last_addr, 24'h3C0000);

        // R11 discard on chip-select drop
        set_cfg(8'h20);
        do_ale(0, 16'h0020, 1);
        do_wr(0, 16'h0011);
        cs_off(8);
        ops0 = wr_ops;
        do_wr(0, 16'h0022);
        chk(wr_ops == ops0, "R11 restart at piece 0", wr_ops - ops0, 0);
        do_wr(0, 16'h0033);
        chk(last_data == 24'h003322 && last_addr == 24'h3C0020, "R11 cs drop discards", last_data, 24'h003322);
        // R11 discard on new address cycle
        do_ale(0, 16'h0021, 1);
        do_wr(0, 16'h0044);
        do_ale(0, 16'h0022, 1);
        do_wr(0, 16'h0055);
        do_wr(0, 16'h0066);
        chk(last_data == 24'h006655 && last_addr == 24'h3C0022, "R11 address cycle discards", last_data, 24'h006655);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule